// File: doc/BRIEF.md
# Dual-source timer clock prescaler

This block divides a timer's source clock and hands the timer a one-cycle counting tick. The source is either the system clock or a slow clock taken from an oscillator pin. The slow clock is meant for real-time-clock use with a watch crystal. A 3-bit select chooses one of three settings: no tick at all, a tick on every source cycle, or a tick on the rising edge of one of six bits of a free-running 10-bit prescaler counter.

The prescaler can be restarted by writing a one to a single bit of an 8-bit control register. In synchronous mode the restart takes effect at once and the bit never reads back as one. In asynchronous mode the request is carried into the slow domain with a toggle handshake. The bit reads as one until the slow-domain counter has been cleared and the acknowledge has come back. A second request made while one is in flight is held and performed afterwards.

Two counter cores exist, one per clock domain, so no clock is ever multiplexed. The system-domain tick is driven only in synchronous mode. The oscillator-domain tick is driven only in asynchronous mode. The mode bit also tells the pad logic that the two oscillator pins are no longer general-purpose port pins.

Top module: `tmr_clk_prescaler`

## Requirements
- R1: After reset, `ctrl_rdata` is 0, both ticks are low and `osc_pins_free` is 0.
- R2: Select code 000 stops the prescaler output: `tick_sys` and `tick_osc` stay low.
- R3: Select code 001 passes the source clock undivided: the tick is high in every cycle of the active source.
- R4: Select codes 010, 011, 100, 101, 110 and 111 divide by 8, 32, 64, 128, 256 and 1024. Each tick lasts one source cycle and follows the rising edge of counter bit 2, 4, 5, 6, 7 or 9. Consecutive ticks are exactly N source cycles apart.
- R5: In synchronous mode, a write with bit 1 of `ctrl_wdata` set clears the counter at the clock edge that samples the write. The next tick is high in the cycle that starts N/2 edges after that edge.
- R6: In synchronous mode (`async_mode` = 0), bit 1 of `ctrl_rdata` always reads 0, including right after a write of one.
- R7: With `async_mode` = 1, `osc_pins_free` is 1, `tick_sys` stays low, and `tick_osc` carries the selected division counted in `clk_osc` cycles. With `async_mode` = 0, `osc_pins_free` is 0.
- R8: In asynchronous mode, a write of one to bit 1 makes bit 1 read one from the next system cycle on. The oscillator-domain counter is cleared a few `clk_osc` edges later, so the first tick after the write arrives about N/2 + 3 oscillator cycles later. Bit 1 reads zero again once the acknowledge has returned.
- R9: Writing zero to bit 1 has no effect: it neither restarts the counter nor clears a pending restart bit.
- R10: Bits 7 to 2 and bit 0 of `ctrl_rdata` always read zero, whatever was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| clk_osc | input | 1 | Slow clock from the oscillator pin |
| async_mode | input | 1 | 1 selects `clk_osc` as prescaler source |
| clk_sel | input | 3 | Stop / undivided / divided-tap select |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data, bit 1 requests a restart |
| ctrl_rdata | output | 8 | Control register read-back |
| osc_pins_free | output | 1 | Oscillator pins released from port use |
| tick_sys | output | 1 | Counting tick in the `clk_sys` domain |
| tick_osc | output | 1 | Counting tick in the `clk_osc` domain |

## Verification
Two collisions are provoked on purpose.

The first is a restart request against the tap's own edge. Each divided-tap run restarts the counter at whatever phase the previous run left it in, so for some taps the write lands where a tick would have fallen. The scoreboard then expects silence until exactly N/2 edges later.

The second is a zero write landing while an asynchronous restart is still in flight. This is provoked by writing zero one cycle after the one. The check is that the bit still reads one and that the first oscillator tick afterwards lands in the restarted slot rather than the natural one.

// File: rtl/pscl_pkg.sv
package pscl_pkg;

   localparam int unsigned SEL_W        = 3;
   localparam int unsigned NUM_SEL      = 1 << SEL_W;
   localparam int unsigned PSCL_MIN_W   = 10;
   localparam int unsigned CTRL_RST_BIT = 1;

   typedef enum logic [SEL_W-1:0] {
      SEL_STOP    = 3'd0,
      SEL_DIV1    = 3'd1,
      SEL_DIV8    = 3'd2,
      SEL_DIV32   = 3'd3,
      SEL_DIV64   = 3'd4,
      SEL_DIV128  = 3'd5,
      SEL_DIV256  = 3'd6,
      SEL_DIV1024 = 3'd7
   } pscl_sel_e;

   // counter bit whose rising edge gives the tick for a divided select code
   function automatic int unsigned tap_bit(input int unsigned code);
      case (code)
         2:       return 2;
         3:       return 4;
         4:       return 5;
         5:       return 6;
         6:       return 7;
         7:       return 9;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/pscl_sync.sv
module pscl_sync #(
   parameter int unsigned STAGES  = 2,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pscl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= {STAGES{RST_VAL}};
      else        sr_q <= {sr_q[STAGES-2:0], d};
   end

   assign q = sr_q[STAGES-1];

endmodule

// File: rtl/pscl_core.sv
module pscl_core
   import pscl_pkg::*;
#(
   parameter int unsigned W = PSCL_MIN_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);

   if (W < PSCL_MIN_W) begin : g_bad_width
      $error("pscl_core: counter narrower than the largest tap");
   end

   logic [W-1:0]       cnt_q;
   logic [W-1:0]       prev_q;
   logic [W-1:0]       rise;
   logic [NUM_SEL-1:0] tap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         prev_q <= '0;
      end else if (clr) begin
         cnt_q  <= '0;
         prev_q <= '0;
      end else begin
         prev_q <= cnt_q;
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign rise = cnt_q & ~prev_q;

   assign tap[SEL_STOP] = 1'b0;
   assign tap[SEL_DIV1] = 1'b1;
   for (genvar gi = 2; gi < NUM_SEL; gi++) begin : g_tap
      assign tap[gi] = rise[tap_bit(gi)];
   end

   assign tick = tap[sel];

   logic unused_rise;
   assign unused_rise = ^rise;

endmodule

// File: rtl/pscl_rst_hs.sv
module pscl_rst_hs #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_sys,
   input  logic rst_n,
   input  logic clk_osc,
   input  logic srst_n,
   input  logic set_req,
   output logic pending,
   output logic osc_clr
);

   logic req_tgl_q;
   logic wait_q;
   logic ack_tgl_q;
   logic ack_s;
   logic req_s;
   logic busy;

   // system domain: toggle request, remember a request made while busy
   pscl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_ack_sync (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .d     (ack_tgl_q),
      .q     (ack_s)
   );

   assign busy = req_tgl_q ^ ack_s;

   always_ff @(posedge clk_sys or negedge rst_n) begin
      if (!rst_n) begin
         req_tgl_q <= 1'b0;
         wait_q    <= 1'b0;
      end else if (!busy && (set_req || wait_q)) begin
         req_tgl_q <= ~req_tgl_q;
         wait_q    <= 1'b0;
      end else if (set_req) begin
         wait_q    <= 1'b1;
      end
   end

   assign pending = busy | wait_q;

   // oscillator domain: detect toggle, clear counter, echo toggle as ack
   pscl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_req_sync (
      .clk   (clk_osc),
      .rst_n (srst_n),
      .d     (req_tgl_q),
      .q     (req_s)
   );

   always_ff @(posedge clk_osc or negedge srst_n) begin
      if (!srst_n) ack_tgl_q <= 1'b0;
      else         ack_tgl_q <= req_s;
   end

   assign osc_clr = req_s ^ ack_tgl_q;

endmodule

// File: rtl/tmr_clk_prescaler.sv
module tmr_clk_prescaler
   import pscl_pkg::*;
#(
   parameter int unsigned PSC_W       = PSCL_MIN_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned CTRL_W      = 8
) (
   input  logic              clk_sys,
   input  logic              rst_n,
   input  logic              clk_osc,
   input  logic              async_mode,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] ctrl_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic              osc_pins_free,
   output logic              tick_sys,
   output logic              tick_osc
);

   if (CTRL_W <= CTRL_RST_BIT) begin : g_bad_ctrl
      $error("tmr_clk_prescaler: control register too narrow");
   end

   logic wr_one;
   logic clr_sys;
   logic set_async;
   logic srst_n;
   logic mode_osc;
   logic rst_pend;
   logic clr_osc;
   logic tick_sys_raw;
   logic tick_osc_raw;

   assign wr_one    = ctrl_wr & ctrl_wdata[CTRL_RST_BIT];
   assign clr_sys   = wr_one & ~async_mode;
   assign set_async = wr_one &  async_mode;

   // reset release and mode bit brought into the oscillator domain
   pscl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_srst_sync (
      .clk   (clk_osc),
      .rst_n (rst_n),
      .d     (1'b1),
      .q     (srst_n)
   );

   pscl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_mode_sync (
      .clk   (clk_osc),
      .rst_n (srst_n),
      .d     (async_mode),
      .q     (mode_osc)
   );

   pscl_rst_hs #(.SYNC_STAGES(SYNC_STAGES)) i_rst_hs (
      .clk_sys (clk_sys),
      .rst_n   (rst_n),
      .clk_osc (clk_osc),
      .srst_n  (srst_n),
      .set_req (set_async),
      .pending (rst_pend),
      .osc_clr (clr_osc)
   );

   pscl_core #(.W(PSC_W)) i_core_sys (
      .clk   (clk_sys),
      .rst_n (rst_n),
      .clr   (clr_sys),
      .sel   (clk_sel),
      .tick  (tick_sys_raw)
   );

   pscl_core #(.W(PSC_W)) i_core_osc (
      .clk   (clk_osc),
      .rst_n (srst_n),
      .clr   (clr_osc),
      .sel   (clk_sel),
      .tick  (tick_osc_raw)
   );

   assign tick_sys      = tick_sys_raw & ~async_mode;
   assign tick_osc      = tick_osc_raw &  mode_osc;
   assign osc_pins_free = async_mode;

   always_comb begin
      ctrl_rdata               = '0;
      ctrl_rdata[CTRL_RST_BIT] = async_mode & rst_pend;
   end

   logic unused_wdata;
   assign unused_wdata = ^ctrl_wdata;

endmodule

// File: rtl/pscl_chk.sv
module pscl_chk
   import pscl_pkg::*;
#(
   parameter int unsigned CTRL_W = 8
) (
   input logic              clk_sys,
   input logic              clk_osc,
   input logic              rst_n,
   input logic              async_mode,
   input logic [SEL_W-1:0]  clk_sel,
   input logic              ctrl_wr,
   input logic [CTRL_W-1:0] ctrl_wdata,
   input logic [CTRL_W-1:0] ctrl_rdata,
   input logic              tick_sys,
   input logic              tick_osc
);

   assert_stop_sys_R2: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (clk_sel == SEL_STOP) |-> !tick_sys);

   assert_stop_osc_R2: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (clk_sel == SEL_STOP) |-> !tick_osc);

   assert_single_tick_sys_R4: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (tick_sys && clk_sel >= SEL_DIV8) |=> (!tick_sys || clk_sel != $past(clk_sel)));

   assert_single_tick_osc_R4: assert property (@(posedge clk_osc) disable iff (!rst_n)
      (tick_osc && clk_sel >= SEL_DIV8) |=> (!tick_osc || clk_sel != $past(clk_sel)));

   assert_restart_quiet_R5: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (!async_mode && ctrl_wr && ctrl_wdata[CTRL_RST_BIT] && clk_sel >= SEL_DIV8)
      |=> (!tick_sys || clk_sel == SEL_DIV1));

   assert_sys_silent_R7: assert property (@(posedge clk_sys) disable iff (!rst_n)
      async_mode |-> !tick_sys);

   assert_bit_held_R8: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (async_mode && ctrl_wr && ctrl_wdata[CTRL_RST_BIT])
      |=> (ctrl_rdata[CTRL_RST_BIT] || !async_mode));

   assert_zero_write_R9: assert property (@(posedge clk_sys) disable iff (!rst_n)
      (async_mode && ctrl_wr && !ctrl_wdata[CTRL_RST_BIT] && !ctrl_rdata[CTRL_RST_BIT])
      |=> !ctrl_rdata[CTRL_RST_BIT]);

endmodule

bind tmr_clk_prescaler pscl_chk #(.CTRL_W(CTRL_W)) i_chk (
   .clk_sys    (clk_sys),
   .clk_osc    (clk_osc),
   .rst_n      (rst_n),
   .async_mode (async_mode),
   .clk_sel    (clk_sel),
   .ctrl_wr    (ctrl_wr),
   .ctrl_wdata (ctrl_wdata),
   .ctrl_rdata (ctrl_rdata),
   .tick_sys   (tick_sys),
   .tick_osc   (tick_osc)
);

// File: tb/test_tmr_clk_prescaler.sv
`timescale 1ns/1ps
module test_tmr_clk_prescaler;

   logic       clk_sys = 1'b0;
   logic       clk_osc = 1'b0;
   logic       rst_n = 1'b0;
   logic       async_mode = 1'b0;
   logic [2:0] clk_sel = 3'd0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_wdata = 8'h00;
   logic [7:0] ctrl_rdata;
   logic       osc_pins_free;
   logic       tick_sys;
   logic       tick_osc;

   always #5  clk_sys = ~clk_sys;
   always #35 clk_osc = ~clk_osc;

   tmr_clk_prescaler i_tmr_clk_prescaler (
      .clk_sys       (clk_sys),
      .rst_n         (rst_n),
      .clk_osc       (clk_osc),
      .async_mode    (async_mode),
      .clk_sel       (clk_sel),
      .ctrl_wr       (ctrl_wr),
      .ctrl_wdata    (ctrl_wdata),
      .ctrl_rdata    (ctrl_rdata),
      .osc_pins_free (osc_pins_free),
      .tick_sys      (tick_sys),
      .tick_osc      (tick_osc)
   );

   int n_run = 0;
   int n_fail = 0;
   int cyc = 0;
   int scyc = 0;
   int exp_q[$];
   bit armed = 1'b0;
   bit quiet = 1'b0;
   int last_otick = 0;
   int otick_cnt = 0;
   bit finished = 1'b0;

   always @(posedge clk_sys) cyc <= cyc + 1;
   always @(posedge clk_osc) scyc <= scyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor: pops expected tick cycles and compares
   int e_pop;
   always @(negedge clk_sys) begin
      if (rst_n && tick_sys) begin
         if (armed) begin
            if (exp_q.size() == 0) check(1'b0, "R4 extra tick", cyc, -1);
            else begin
               e_pop = exp_q.pop_front();
               check(cyc == e_pop, "R4/R5 tick cycle", cyc, e_pop);
            end
         end else if (quiet) begin
            check(1'b0, "R2/R7 tick_sys must be low", 1, 0);
         end
      end
   end

   always @(negedge clk_osc) begin
      if (rst_n && tick_osc) begin
         last_otick = scyc;
         otick_cnt++;
      end
   end

   task automatic wr(input logic [7:0] d);
      @(negedge clk_sys);
      ctrl_wr = 1'b1;
      ctrl_wdata = d;
      @(negedge clk_sys);
      ctrl_wr = 1'b0;
      ctrl_wdata = 8'h00;
   endtask

   // driver: restart in sync mode, push expected tick cycles
   task automatic run_tap(input logic [2:0] s, input int half, input int ntick, input bit poke0);
      int n;
      int used;
      @(negedge clk_sys);
      armed = 1'b0;
      clk_sel = s;
      ctrl_wr = 1'b1;
      ctrl_wdata = 8'h02;
      n = cyc;
      for (int j = 0; j < ntick; j++) exp_q.push_back(n + 1 + half + 2 * half * j);
      @(negedge clk_sys);
      ctrl_wr = 1'b0;
      ctrl_wdata = 8'h00;
      armed = 1'b1;
      check(ctrl_rdata == 8'h00, "R6 sync read after restart", ctrl_rdata, 0);
      used = 0;
      if (poke0) begin
         repeat (half + 3) @(negedge clk_sys);
         wr(8'h00);  // R9: must not move the schedule
         used = half + 5;
      end
      repeat (2 * half * ntick - used) @(negedge clk_sys);
      check(exp_q.size() == 0, "R4 missing ticks", exp_q.size(), 0);
      exp_q.delete();
      armed = 1'b0;
   endtask

   task automatic wait_otick(input int target, output bit ok);
      ok = 1'b0;
      for (int k = 0; k < 60000; k++) begin
         @(negedge clk_sys);
         if (otick_cnt >= target) begin
            ok = 1'b1;
            break;
         end
      end
   endtask

   initial begin
      bit ok;
      int c0;
      int w_s;
      int t1;
      int k_clr;
      int hi_cnt;
      int cnt;

      repeat (3) @(negedge clk_sys);
      check(ctrl_rdata == 8'h00, "R1 rdata at reset", ctrl_rdata, 0);
      check(tick_sys == 1'b0, "R1 tick_sys at reset", tick_sys, 0);
      check(osc_pins_free == 1'b0, "R1 osc_pins_free at reset", osc_pins_free, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk_sys);
      check(osc_pins_free == 1'b0, "R7 pins kept in sync mode", osc_pins_free, 0);

      // divided taps in sync mode
      run_tap(3'b010, 4, 5, 1'b1);
      run_tap(3'b011, 16, 3, 1'b0);
      run_tap(3'b100, 32, 3, 1'b0);
      run_tap(3'b101, 64, 2, 1'b0);
      run_tap(3'b110, 128, 2, 1'b0);
      run_tap(3'b111, 512, 2, 1'b0);
      run_tap(3'b010, 4, 3, 1'b0);

      // undivided
      @(negedge clk_sys);
      clk_sel = 3'b001;
      hi_cnt = 0;
      for (int j = 0; j < 10; j++) begin
         @(negedge clk_sys);
         if (tick_sys) hi_cnt++;
      end
      check(hi_cnt == 10, "R3 undivided tick every cycle", hi_cnt, 10);

      // reserved bits in sync mode
      wr(8'hFF);
      check(ctrl_rdata == 8'h00, "R10/R6 read after 0xFF write", ctrl_rdata, 0);

      // stopped
      @(negedge clk_sys);
      clk_sel = 3'b000;
      quiet = 1'b1;
      cnt = otick_cnt;
      hi_cnt = 0;
      for (int j = 0; j < 300; j++) begin
         @(negedge clk_sys);
         if (tick_sys) hi_cnt++;
      end
      check(hi_cnt == 0, "R2 stopped tick_sys", hi_cnt, 0);
      check(otick_cnt == cnt, "R2 stopped tick_osc", otick_cnt - cnt, 0);

      // asynchronous mode
      @(negedge clk_sys);
      async_mode = 1'b1;
      clk_sel = 3'b110;
      @(negedge clk_sys);
      check(osc_pins_free == 1'b1, "R7 pins released", osc_pins_free, 1);
      c0 = otick_cnt;
      wait_otick(c0 + 1, ok);
      check(ok, "R7 tick_osc present in async mode", ok, 1);
      repeat (30) @(negedge clk_osc);
      @(negedge clk_sys);
      ctrl_wr = 1'b1;
      ctrl_wdata = 8'hFF;
      w_s = scyc;
      c0 = otick_cnt;
      @(negedge clk_sys);
      ctrl_wdata = 8'h00;  // zero write while the restart is in flight
      check(ctrl_rdata == 8'h02, "R8/R10 bit reads one after write", ctrl_rdata, 2);
      @(negedge clk_sys);
      ctrl_wr = 1'b0;
      check(ctrl_rdata[1] == 1'b1, "R9 zero write keeps pending bit", ctrl_rdata[1], 1);
      k_clr = -1;
      for (int k = 0; k < 600; k++) begin
         @(negedge clk_sys);
         if (!ctrl_rdata[1]) begin
            k_clr = k;
            break;
         end
      end
      check(k_clr >= 5, "R8 bit clears after handshake", k_clr, 5);
      wait_otick(c0 + 1, ok);
      check(ok && (last_otick - w_s) >= 128 && (last_otick - w_s) <= 140,
            "R8 first osc tick after restart", last_otick - w_s, 131);

      // osc-domain period
      @(negedge clk_sys);
      clk_sel = 3'b010;
      c0 = otick_cnt;
      wait_otick(c0 + 2, ok);
      t1 = last_otick;
      wait_otick(c0 + 3, ok);
      check(ok && (last_otick - t1) == 8, "R7/R4 osc period /8", last_otick - t1, 8);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!finished) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule